// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

This block is a full-duplex byte port in which one serial clock moves data in both directions. A host writes a byte into a transmit holding register and reads completed bytes from a receive holding register. A shift path sits behind each holding register. Every frame is exactly eight data bits, with no start, stop or parity bits. The serial clock can come from one of two sources. In master mode the block makes it from a prescaler and an 8-bit divider and drives it on a pin. In slave mode it takes the clock from an input pin through a synchronizer.

Because the receiver is clocked by the transmitter's frame, a byte can only be received while transmission is enabled and a transmit byte has been loaded. Configuration inputs select:
- the clock polarity,
- the bit order (bit 0 first or bit 7 first),
- logical inversion of both data directions,
- whether the transmit interrupt fires when the holding register empties or when the frame ends,
- a CTS gate on starting a frame,
- an RTS output that tells the peer whether the receiver can take a byte.

An overrun flag catches a byte that arrives while the previous one is still unread.

Top module: `csio_top`

## Requirements
- R1: After reset, tx_empty=1, rx_full=0, overrun=0, tx_irq=0, rx_irq=0, sdo=1, and sck_out sits at its idle level (1 when pol=0).
- R2: In master mode, consecutive sampling edges of sck_out are 2*(brg+1) fj periods apart. fj is selected by fj_sel: 0 gives clk, 1 gives clk/8, 2 gives clk/2^pre_n (pre_n=0 means no division).
- R3: A frame starts only when tx_en=1, the transmit register holds data (tx_empty=0), and, if cts_en=1, cts_n=0. While any of these is missing, no clock edges occur and tx_empty stays 0.
- R4: A frame carries 8 bits. With msb_first=0 the i-th bit on the wire is data bit i. With msb_first=1 it is data bit 7-i. Received bits are placed in the same order.
- R5: With pol=0, sck idles at 1, sdo changes on falling edges and sdi is sampled on rising edges. With pol=1, both edges and the idle level are reversed.
- R6: With invert=1, every transmitted bit is complemented on sdo and every received bit is complemented from sdi.
- R7: A byte is received only when rx_en=1 and tx_en=1 during a frame started from a loaded transmit register. Otherwise rx_full stays 0 and rx_irq does not pulse.
- R8: With tirq_sel=0, tx_irq pulses for one cycle when the holding byte moves into the shift path, before the first sampling edge. With tirq_sel=1, it pulses when the eighth bit has been sampled.
- R9: When a byte completes, rx_irq pulses once, rx_full becomes 1 and rx_data shows the byte. A one-cycle rx_rd pulse clears rx_full.
- R10: If the 7th bit of a byte is sampled while rx_full=1, overrun becomes 1 and that byte raises no rx_irq. overrun clears while rx_en=0.
- R11: With rts_en=1, rts_n is 0 while rx_en=1 and rx_full=0, and 1 otherwise. With rts_en=0, rts_n is 1.
- R12: With master=0, sck_oe=0, and frames are clocked by sck_in through a two-stage synchronizer using the same edge rules as R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master | input | 1 | 1: internal serial clock driven out; 0: clock taken from sck_in |
| pol | input | 1 | Serial clock polarity select |
| msb_first | input | 1 | 1: bit 7 first; 0: bit 0 first |
| invert | input | 1 | Complement transmit and receive data |
| tirq_sel | input | 1 | 0: tx_irq on buffer load; 1: tx_irq on frame end |
| cts_en | input | 1 | Gate frame start on cts_n |
| rts_en | input | 1 | Enable rts_n flow-control output |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| fj_sel | input | 2 | Prescaler source: 0 clk, 1 clk/8, 2 clk/2^pre_n |
| pre_n | input | 4 | Power-of-two prescale exponent |
| brg | input | 8 | Divider setting m |
| tx_wr | input | 1 | Write pulse for tx_data |
| tx_data | input | 8 | Byte to transmit |
| rx_rd | input | 1 | Read pulse, clears rx_full |
| rx_data | output | 8 | Last received byte |
| tx_empty | output | 1 | Transmit holding register empty |
| rx_full | output | 1 | Unread received byte present |
| overrun | output | 1 | Overrun flag |
| tx_irq | output | 1 | Transmit interrupt pulse |
| rx_irq | output | 1 | Receive interrupt pulse |
| sck_in | input | 1 | External serial clock |
| sck_out | output | 1 | Serial clock output |
| sck_oe | output | 1 | Serial clock output enable |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| cts_n | input | 1 | Clear-to-send, active low |
| rts_n | output | 1 | Request-to-send, active low |

## Verification
Several properties are checked on every cycle by the in-line assertions:
- drive and sample events never coincide,
- every bit is driven before it is sampled,
- the master clock moves only on divider ticks,
- rx_irq always comes with rx_full,
- an overrun-tainted byte raises no interrupt,
- overrun clears once receive is off,
- RTS deasserts while a byte waits unread.

The directed scenarios are the only means of showing other behaviour:
- the bit values and order on the wire, and the effect of inversion,
- the exact sampling-edge spacing for each prescaler choice,
- the two transmit interrupt points,
- the start gating by enable and CTS,
- the slave-clocked loopback.

// File: rtl/csio_pkg.sv
package csio_pkg;
  localparam int CSIO_DATA_W = 8;
  localparam int CSIO_IDX_W  = $clog2(CSIO_DATA_W);

  typedef enum logic [1:0] {
    FJ_BASE = 2'd0,
    FJ_DIV8 = 2'd1,
    FJ_POW2 = 2'd2,
    FJ_RSVD = 2'd3
  } fj_sel_e;

  // wire order -> storage position
  function automatic logic [CSIO_IDX_W-1:0] bit_pos(input logic [CSIO_IDX_W-1:0] idx,
                                                    input logic msb_first);
    bit_pos = msb_first ? CSIO_IDX_W'(CSIO_DATA_W - 1) - idx : idx;
  endfunction
endpackage

// File: rtl/csio_clkgen.sv
module csio_clkgen
  import csio_pkg::*;
#(
  parameter int BRG_W  = 8,
  parameter int PRE_W  = 4,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             master,
  input  logic             pol,
  input  logic [1:0]       fj_sel,
  input  logic [PRE_W-1:0] pre_n,
  input  logic [BRG_W-1:0] brg,
  input  logic             active,
  input  logic             sck_in,
  output logic             sck_out,
  output logic             drive_ev,
  output logic             samp_ev
);
  localparam int PCNT_W = (1 << PRE_W) - 1;

  function automatic logic fj_hit(input logic [PCNT_W-1:0] cnt, input logic [1:0] sel,
                                  input logic [PRE_W-1:0] n);
    logic [PCNT_W-1:0] mask;
    mask = (PCNT_W'(1) << n) - PCNT_W'(1);
    case (fj_sel_e'(sel))
      FJ_DIV8: fj_hit = &cnt[2:0];
      FJ_POW2: fj_hit = &(cnt | ~mask);
      default: fj_hit = 1'b1;
    endcase
  endfunction

  logic [PCNT_W-1:0] pcnt;
  logic [BRG_W-1:0]  brg_cnt;
  logic              fj_tick, half_ev, idle_lvl, sck_q;
  logic              m_drive, m_samp, s_drive, s_samp, s_cur, s_prev;

  assign idle_lvl = ~pol;
  assign fj_tick  = fj_hit(pcnt, fj_sel, pre_n);
  assign half_ev  = active && fj_tick && (brg_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt    <= '0;
      brg_cnt <= '0;
      sck_q   <= 1'b1;
    end else begin
      pcnt <= pcnt + PCNT_W'(1);
      if (!active) begin
        brg_cnt <= brg;
        sck_q   <= idle_lvl;
      end else begin
        if (fj_tick) brg_cnt <= (brg_cnt == '0) ? brg : brg_cnt - BRG_W'(1);
        if (half_ev) sck_q <= ~sck_q;
      end
    end
  end

  assign m_drive = half_ev && (sck_q == idle_lvl);
  assign m_samp  = half_ev && (sck_q != idle_lvl);

  generate
    if (SYNC_N <= 1) begin : g_sync1
      logic sq;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sq <= 1'b1;
        else        sq <= sck_in;
      end
      assign s_cur = sq;
    end else begin : g_syncn
      logic [SYNC_N-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[SYNC_N-2:0], sck_in};
      end
      assign s_cur = chain[SYNC_N-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s_prev <= 1'b1;
    else        s_prev <= s_cur;
  end

  assign s_drive = active && (s_prev == idle_lvl) && (s_cur != idle_lvl);
  assign s_samp  = active && (s_prev != idle_lvl) && (s_cur == idle_lvl);

  assign drive_ev = master ? m_drive : s_drive;
  assign samp_ev  = master ? m_samp  : s_samp;
  assign sck_out  = (master && active) ? sck_q : idle_lvl;

  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(drive_ev && samp_ev)); // R5
  AST_SCK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (master && active && $past(master && active) && !$past(half_ev)) |-> $stable(sck_q)); // R2
endmodule

// File: rtl/csio_tx.sv
module csio_tx
  import csio_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tx_wr,
  input  logic [CSIO_DATA_W-1:0] tx_data,
  input  logic                  tx_en,
  input  logic                  cts_en,
  input  logic                  cts_n,
  input  logic                  msb_first,
  input  logic                  invert,
  input  logic                  tirq_sel,
  input  logic                  drive_ev,
  input  logic                  samp_ev,
  output logic                  tx_empty,
  output logic                  active,
  output logic [CSIO_IDX_W-1:0] smp_idx,
  output logic                  sdo,
  output logic                  tx_irq
);
  logic [CSIO_DATA_W-1:0] hold_q, shreg;
  logic [CSIO_IDX_W-1:0]  drv_idx;
  logic                   start_ev, last_ev, next_bit;

  assign start_ev = !active && tx_en && !tx_empty && (!cts_en || !cts_n);
  assign last_ev  = active && samp_ev && (smp_idx == CSIO_IDX_W'(CSIO_DATA_W - 1));
  assign next_bit = shreg[bit_pos(drv_idx, msb_first)] ^ invert;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q   <= '0;
      tx_empty <= 1'b1;
      shreg    <= '0;
      active   <= 1'b0;
      drv_idx  <= '0;
      smp_idx  <= '0;
      sdo      <= 1'b1;
      tx_irq   <= 1'b0;
    end else begin
      if (tx_wr) begin
        hold_q   <= tx_data;
        tx_empty <= 1'b0;
      end else if (start_ev) begin
        tx_empty <= 1'b1;
      end
      if (start_ev) begin
        shreg   <= hold_q;
        active  <= 1'b1;
        drv_idx <= '0;
        smp_idx <= '0;
      end else if (active) begin
        if (drive_ev) begin
          sdo     <= next_bit;
          drv_idx <= drv_idx + CSIO_IDX_W'(1);
        end
        if (samp_ev) begin
          smp_idx <= smp_idx + CSIO_IDX_W'(1);
          if (last_ev) active <= 1'b0;
        end
      end
      tx_irq <= (start_ev && !tirq_sel) || (last_ev && tirq_sel);
    end
  end

  AST_TXIRQ_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_irq && !tirq_sel && !$past(tx_wr)) |-> tx_empty); // R8
  AST_DRIVE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (active && samp_ev) |-> (drv_idx == smp_idx + CSIO_IDX_W'(1))); // R4
  AST_TXIRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |=> !tx_irq); // R8
endmodule

// File: rtl/csio_rx.sv
module csio_rx
  import csio_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rx_en,
  input  logic                   tx_en,
  input  logic                   active,
  input  logic                   samp_ev,
  input  logic [CSIO_IDX_W-1:0]  smp_idx,
  input  logic                   msb_first,
  input  logic                   invert,
  input  logic                   sdi,
  input  logic                   rx_rd,
  input  logic                   rts_en,
  output logic [CSIO_DATA_W-1:0] rx_data,
  output logic                   rx_full,
  output logic                   overrun,
  output logic                   rx_irq,
  output logic                   rts_n
);
  localparam logic [CSIO_IDX_W-1:0] OVR_IDX  = CSIO_IDX_W'(CSIO_DATA_W - 2);
  localparam logic [CSIO_IDX_W-1:0] LAST_IDX = CSIO_IDX_W'(CSIO_DATA_W - 1);

  logic [CSIO_DATA_W-1:0] shreg, asm_next;
  logic                   take, ovr_pend, ovr_hit, done_ev;

  assign take    = rx_en && tx_en && active && samp_ev;
  assign ovr_hit = take && (smp_idx == OVR_IDX) && rx_full;
  assign done_ev = take && (smp_idx == LAST_IDX);

  always_comb begin
    asm_next = shreg;
    asm_next[bit_pos(smp_idx, msb_first)] = sdi ^ invert;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg    <= '0;
      rx_data  <= '0;
      rx_full  <= 1'b0;
      overrun  <= 1'b0;
      ovr_pend <= 1'b0;
      rx_irq   <= 1'b0;
    end else begin
      rx_irq <= 1'b0;
      if (take) shreg <= asm_next;
      if (take && smp_idx == '0) ovr_pend <= 1'b0;
      else if (ovr_hit)         ovr_pend <= 1'b1;
      if (!rx_en)       overrun <= 1'b0;
      else if (ovr_hit) overrun <= 1'b1;
      if (done_ev) begin
        rx_data <= asm_next;
        if (!ovr_pend) begin
          rx_full <= 1'b1;
          rx_irq  <= 1'b1;
        end
      end else if (rx_rd) begin
        rx_full <= 1'b0;
      end
    end
  end

  assign rts_n = rts_en ? !(rx_en && !rx_full) : 1'b1;

  AST_RXIRQ_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rx_full); // R9
  AST_OVR_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ev && ovr_pend) |=> !rx_irq); // R10
  AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !overrun); // R10
  AST_RX_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en || !tx_en) |=> !rx_irq); // R7
  AST_RTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_en && rx_full) |-> rts_n); // R11
endmodule

// File: rtl/csio_top.sv
module csio_top
  import csio_pkg::*;
#(
  parameter int BRG_W  = 8,
  parameter int PRE_W  = 4,
  parameter int SYNC_N = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   master,
  input  logic                   pol,
  input  logic                   msb_first,
  input  logic                   invert,
  input  logic                   tirq_sel,
  input  logic                   cts_en,
  input  logic                   rts_en,
  input  logic                   tx_en,
  input  logic                   rx_en,
  input  logic [1:0]             fj_sel,
  input  logic [PRE_W-1:0]       pre_n,
  input  logic [BRG_W-1:0]       brg,
  input  logic                   tx_wr,
  input  logic [CSIO_DATA_W-1:0] tx_data,
  input  logic                   rx_rd,
  output logic [CSIO_DATA_W-1:0] rx_data,
  output logic                   tx_empty,
  output logic                   rx_full,
  output logic                   overrun,
  output logic                   tx_irq,
  output logic                   rx_irq,
  input  logic                   sck_in,
  output logic                   sck_out,
  output logic                   sck_oe,
  output logic                   sdo,
  input  logic                   sdi,
  input  logic                   cts_n,
  output logic                   rts_n
);
  logic                  active, drive_ev, samp_ev;
  logic [CSIO_IDX_W-1:0] smp_idx;

  csio_clkgen #(.BRG_W(BRG_W), .PRE_W(PRE_W), .SYNC_N(SYNC_N)) u_clk (
    .clk(clk), .rst_n(rst_n), .master(master), .pol(pol), .fj_sel(fj_sel),
    .pre_n(pre_n), .brg(brg), .active(active), .sck_in(sck_in),
    .sck_out(sck_out), .drive_ev(drive_ev), .samp_ev(samp_ev)
  );

  csio_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .tx_data(tx_data), .tx_en(tx_en),
    .cts_en(cts_en), .cts_n(cts_n), .msb_first(msb_first), .invert(invert),
    .tirq_sel(tirq_sel), .drive_ev(drive_ev), .samp_ev(samp_ev),
    .tx_empty(tx_empty), .active(active), .smp_idx(smp_idx), .sdo(sdo), .tx_irq(tx_irq)
  );

  csio_rx u_rx (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tx_en(tx_en), .active(active),
    .samp_ev(samp_ev), .smp_idx(smp_idx), .msb_first(msb_first), .invert(invert),
    .sdi(sdi), .rx_rd(rx_rd), .rts_en(rts_en), .rx_data(rx_data), .rx_full(rx_full),
    .overrun(overrun), .rx_irq(rx_irq), .rts_n(rts_n)
  );

  assign sck_oe = master;

  AST_SLAVE_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
    !master |-> !sck_oe); // R12
endmodule

// File: tb/sim_csio_top.sv
`timescale 1ns/1ps
module sim_csio_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic master = 1'b1, pol = 1'b0, msb_first = 1'b0, invert = 1'b0, tirq_sel = 1'b0;
  logic cts_en = 1'b0, rts_en = 1'b0, tx_en = 1'b1, rx_en = 1'b0;
  logic [1:0] fj_sel = 2'd0;
  logic [3:0] pre_n = 4'd0;
  logic [7:0] brg = 8'd1, tx_data = 8'h00, rx_data;
  logic tx_wr = 1'b0, rx_rd = 1'b0, tx_empty, rx_full, overrun, tx_irq, rx_irq;
  logic sck_in = 1'b1, sck_out, sck_oe, sdo, sdi, cts_n = 1'b1, rts_n;
  logic lb = 1'b1, sdi_drv = 1'b0;

  int n_chk = 0, n_fail = 0;
  int samp_cnt = 0, irq_at = -1, last_gap = 0, last_samp = 0, cyc = 0;
  int txirq_cnt = 0, rxirq_cnt = 0;
  logic [7:0] cap = 8'h00;
  logic prev_eff = 1'b1, clr_req = 1'b0;

  assign sdi = lb ? sdo : sdi_drv;
  always #5 clk = ~clk;

  csio_top u0 (
    .clk(clk), .rst_n(rst_n), .master(master), .pol(pol), .msb_first(msb_first),
    .invert(invert), .tirq_sel(tirq_sel), .cts_en(cts_en), .rts_en(rts_en),
    .tx_en(tx_en), .rx_en(rx_en), .fj_sel(fj_sel), .pre_n(pre_n), .brg(brg),
    .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd), .rx_data(rx_data),
    .tx_empty(tx_empty), .rx_full(rx_full), .overrun(overrun), .tx_irq(tx_irq),
    .rx_irq(rx_irq), .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe),
    .sdo(sdo), .sdi(sdi), .cts_n(cts_n), .rts_n(rts_n)
  );

  // wire monitor: sampling edge = transition into the idle level
  always @(negedge clk) begin
    logic eff;
    eff = master ? sck_out : sck_in;
    cyc = cyc + 1;
    if (clr_req) begin
      samp_cnt = 0; irq_at = -1; cap = 8'h00;
    end else if (rst_n && eff != prev_eff && eff == ~pol) begin
      if (samp_cnt < 8) cap[samp_cnt] = sdo;
      if (samp_cnt > 0) last_gap = cyc - last_samp;
      last_samp = cyc;
      samp_cnt = samp_cnt + 1;
    end
    prev_eff = eff;
    if (tx_irq) begin irq_at = samp_cnt; txirq_cnt = txirq_cnt + 1; end
    if (rx_irq) rxirq_cnt = rxirq_cnt + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] wire_bits(input logic [7:0] d, input logic m, input logic v);
    logic [7:0] w;
    for (int i = 0; i < 8; i++) w[i] = (m ? d[7-i] : d[i]) ^ v;
    return w;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic clear_mon();
    tick(3);
    clr_req = 1'b1;
    @(negedge clk); #1;
    clr_req = 1'b0;
  endtask

  task automatic write_byte(input logic [7:0] d);
    clear_mon();
    tick(1);
    tx_data = d; tx_wr = 1'b1;
    tick(1);
    tx_wr = 1'b0;
  endtask

  task automatic wait_frame();
    for (int i = 0; i < 20000 && samp_cnt < 8; i++) @(negedge clk);
    tick(4);
  endtask

  task automatic read_rx();
    tick(1); rx_rd = 1'b1; tick(1); rx_rd = 1'b0; tick(1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 tx_empty", tx_empty, 1); check("R1 rx_full", rx_full, 0);
    check("R1 overrun", overrun, 0);   check("R1 sdo", sdo, 1);
    check("R1 sck idle", sck_out, 1);  check("R1 irqs", {tx_irq, rx_irq}, 0);
  endtask

  task automatic t_txirq();
    int c0;
    tirq_sel = 1'b0; c0 = txirq_cnt;
    write_byte(8'h5A); wait_frame();
    check("R8 sel0 point", irq_at, 0); check("R8 sel0 count", txirq_cnt - c0, 1);
    tirq_sel = 1'b1; c0 = txirq_cnt;
    write_byte(8'hA5); wait_frame();
    check("R8 sel1 point", irq_at, 8); check("R8 sel1 count", txirq_cnt - c0, 1);
    tirq_sel = 1'b0;
  endtask

  task automatic t_order_invert();
    logic [7:0] pats [4] = '{8'h1E, 8'hC3, 8'h81, 8'h6D};
    rx_en = 1'b1; lb = 1'b1;
    for (int k = 0; k < 4; k++) begin
      int c0;
      msb_first = k[0]; invert = k[1]; c0 = rxirq_cnt;
      write_byte(pats[k]); wait_frame();
      check("R4 R6 wire bits", cap, wire_bits(pats[k], k[0], k[1]));
      check("R9 rx_data", rx_data, pats[k]);
      check("R9 rx_full", rx_full, 1);
      check("R9 rx_irq once", rxirq_cnt - c0, 1);
      read_rx();
      check("R9 read clears", rx_full, 0);
    end
    msb_first = 1'b0; invert = 1'b0; rx_en = 1'b0;
  endtask

  task automatic t_baud(input logic [1:0] s, input logic [3:0] n, input logic [7:0] m,
                        input int exp_gap);
    fj_sel = s; pre_n = n; brg = m;
    write_byte(8'h96); wait_frame();
    check("R2 edge spacing", last_gap, exp_gap);
  endtask

  task automatic t_polarity();
    pol = 1'b1; rx_en = 1'b1;
    tick(3);
    @(negedge clk); check("R5 idle low", sck_out, 0);
    write_byte(8'h3C); wait_frame();
    check("R5 pol1 wire", cap, wire_bits(8'h3C, 1'b0, 1'b0));
    check("R5 pol1 rx", rx_data, 8'h3C);
    read_rx();
    pol = 1'b0; rx_en = 1'b0;
    tick(3);
    @(negedge clk); check("R5 idle high", sck_out, 1);
  endtask

  task automatic t_start_gate();
    tx_en = 1'b0;
    write_byte(8'h77); tick(100);
    check("R3 tx_en gate edges", samp_cnt, 0); check("R3 tx_en gate empty", tx_empty, 0);
    tx_en = 1'b1; wait_frame();
    check("R3 start after enable", samp_cnt, 8); check("R3 emptied", tx_empty, 1);
    cts_en = 1'b1; cts_n = 1'b1;
    write_byte(8'h11); tick(100);
    check("R3 cts gate edges", samp_cnt, 0); check("R3 cts gate empty", tx_empty, 0);
    cts_n = 1'b0; wait_frame();
    check("R3 start after cts", samp_cnt, 8);
    cts_en = 1'b0; cts_n = 1'b1;
  endtask

  task automatic t_rx_gate();
    int c0;
    rx_en = 1'b0; c0 = rxirq_cnt;
    write_byte(8'hE7); wait_frame();
    check("R7 no rx_full", rx_full, 0); check("R7 no rx_irq", rxirq_cnt - c0, 0);
  endtask

  task automatic t_overrun();
    int c0;
    rx_en = 1'b1; c0 = rxirq_cnt;
    write_byte(8'h21); wait_frame();
    check("R10 first byte", rx_data, 8'h21);
    write_byte(8'h43); wait_frame();
    check("R10 overrun set", overrun, 1);
    check("R10 no irq for lost byte", rxirq_cnt - c0, 1);
    check("R10 still full", rx_full, 1);
    rx_en = 1'b0; tick(2);
    @(negedge clk); check("R10 cleared by rx off", overrun, 0);
    read_rx();
  endtask

  task automatic t_rts();
    rts_en = 1'b1; rx_en = 1'b1; tick(1);
    @(negedge clk); check("R11 ready low", rts_n, 0);
    write_byte(8'h5F); wait_frame();
    check("R11 busy high", rts_n, 1);
    read_rx();
    @(negedge clk); check("R11 low after read", rts_n, 0);
    rx_en = 1'b0; tick(1);
    @(negedge clk); check("R11 high when rx off", rts_n, 1);
    rts_en = 1'b0;
  endtask

  task automatic t_slave();
    master = 1'b0; sck_in = 1'b1; rx_en = 1'b1; lb = 1'b1;
    tick(2);
    @(negedge clk); check("R12 sck_oe low", sck_oe, 0);
    write_byte(8'hB4); tick(5);
    for (int b = 0; b < 8; b++) begin
      sck_in = 1'b0; tick(10);
      sck_in = 1'b1; tick(10);
    end
    tick(5);
    check("R12 slave wire", cap, wire_bits(8'hB4, 1'b0, 1'b0));
    check("R12 slave rx", rx_data, 8'hB4);
    check("R12 slave done", tx_empty, 1);
    read_rx();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick(3);
    t_reset();
    rst_n = 1'b1;
    tick(2);
    t_txirq();
    t_order_invert();
    t_baud(2'd0, 4'd0, 8'd3, 8);
    t_baud(2'd1, 4'd0, 8'd0, 16);
    t_baud(2'd2, 4'd2, 8'd1, 16);
    t_baud(2'd2, 4'd0, 8'd2, 6);
    fj_sel = 2'd0; pre_n = 4'd0; brg = 8'd1;
    t_polarity();
    t_start_gate();
    t_rx_gate();
    t_overrun();
    t_rts();
    t_slave();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule